// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block drives the command and address pins of one single-rank SDR SDRAM on a local bus. Software holds a 32-bit machine-mode register. A three-bit operation field in that register selects what the next access to the memory window does. In normal operation each access becomes an ordinary activate followed by a read or a write with auto-precharge. When a special operation is selected, each write access to the window moves no data. It fires the selected SDRAM command once: precharge-all, auto-refresh or mode-register-set.

Software brings the device up by stepping the operation field and poking the window, with a pause of about 100 µs between triggers: one precharge-all, then eight auto-refreshes, then one mode-register write, then back to normal. The low part of the mode register supplies the mode-register-set address and bank, and it is kept while only the operation bits change. A refresh timer, built from a prescaler and a period count, requests automatic refreshes in normal operation. A busy flag covers each command's recovery time.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset all four command pins are high (deselect), the address and bank pins are zero and busy is low.
- R2: The operation field is bits [29:27] of the mode register: 000 normal, 101 precharge-all, 001 auto-refresh, 011 mode-register-set. Any other code makes every access do nothing. Reads done in a special operation also do nothing.
- R3: In a special operation each write access issues exactly one selected command. It appears on the pins, with busy rising, in the cycle after the clock edge that sampled the access, and every other cycle of that busy window is deselect.
- R4: Precharge-all drives {cs_n,ras_n,cas_n,we_n}=0010, with address bit A10 high and all other address and bank bits zero.
- R5: Auto-refresh drives 0001 with address and bank zero. Mode-register-set drives 0000 with address = mode register bits [12:0] and bank = bits [14:13].
- R6: A normal access drives activate (0011) with row = access address bits [21:9] and bank = bits [23:22]. Exactly TRCD cycles later it drives read (0101) or write (0100) with the column (bits [8:0]) on the low address bits, A10 high and the same bank.
- R7: Busy stays high for TRP cycles after precharge-all, TRFC after auto-refresh, TMRD after mode-register-set and TRCD+TRP after a normal access, counting the command cycle. Accesses presented while busy is high are ignored.
- R8: With prescaler P and period T (T nonzero), automatic refreshes appear every (P+1)*(T+1) cycles while the block is idle in normal operation. T=0 stops them. Writing either timer register restarts the count.
- R9: A due automatic refresh is held while the operation field is not normal. It is issued in the cycle after the first edge at which the field is normal again.
- R10: Changing only the operation bits leaves the mode-register-set address and bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load the machine-mode register |
| mode_wdata | input | 32 | Machine-mode register value |
| presc_we | input | 1 | Load the refresh prescaler |
| presc_wdata | input | 8 | Refresh prescaler value P |
| period_we | input | 1 | Load the refresh period |
| period_wdata | input | 8 | Refresh period value T (0 = off) |
| acc_valid | input | 1 | Access to the SDRAM window this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 24 | Window address {bank, row, column} |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | SDRAM address pins |
| sd_ba | output | 2 | SDRAM bank pins |
| busy | output | 1 | Command recovery in progress |

## Verification
A wrong sequencer state shows on the pins at once, in the cycle after the access is sampled: a wrong command code, a wrong A10 or mode address, or a busy flag that starts late. A wrong recovery count shows as a busy window that is too short or too long. In the worst case this appears only when the next access is taken or dropped. Faults in the refresh timer appear after a whole refresh interval, as a wrong spacing between automatic refreshes, or as a refresh that leaks out, or never comes, after the operation field leaves or returns to normal.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // pin order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_MRS   = 4'b0000
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT_WAIT,
    ST_RECOVER
  } seq_st_e;

  localparam int          OP_LSB     = 27;
  localparam logic [2:0]  OP_NORMAL  = 3'b000;
  localparam logic [2:0]  OP_REFRESH = 3'b001;
  localparam logic [2:0]  OP_MODESET = 3'b011;
  localparam logic [2:0]  OP_PREALL  = 3'b101;
  localparam int          A10_BIT    = 10;
endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int PRESC_W  = 8,
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                presc_we,
  input  logic [PRESC_W-1:0]  presc_wdata,
  input  logic                period_we,
  input  logic [PERIOD_W-1:0] period_wdata,
  input  logic                ref_ack,
  output logic                ref_pend
);
  logic [PRESC_W-1:0]  presc_val_q, presc_val_d, presc_cnt_q, presc_cnt_d;
  logic [PERIOD_W-1:0] period_val_q, period_val_d, period_cnt_q, period_cnt_d;
  logic                pend_q, pend_d, expire;

  always_comb begin
    presc_val_d  = presc_we  ? presc_wdata  : presc_val_q;
    period_val_d = period_we ? period_wdata : period_val_q;
    presc_cnt_d  = presc_cnt_q;
    period_cnt_d = period_cnt_q;
    expire       = 1'b0;
    if (presc_we || period_we || (period_val_q == '0)) begin
      presc_cnt_d  = '0;
      period_cnt_d = '0;
    end else if (presc_cnt_q == presc_val_q) begin
      presc_cnt_d = '0;
      if (period_cnt_q == period_val_q) begin
        period_cnt_d = '0;
        expire       = 1'b1;
      end else begin
        period_cnt_d = period_cnt_q + 1'b1;
      end
    end else begin
      presc_cnt_d = presc_cnt_q + 1'b1;
    end
    pend_d = (pend_q && !ref_ack) || expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_val_q  <= '0;
      period_val_q <= '0;
      presc_cnt_q  <= '0;
      period_cnt_q <= '0;
      pend_q       <= 1'b0;
    end else begin
      presc_val_q  <= presc_val_d;
      period_val_q <= period_val_d;
      presc_cnt_q  <= presc_cnt_d;
      period_cnt_q <= period_cnt_d;
      pend_q       <= pend_d;
    end
  end

  assign ref_pend = pend_q;

  // R8: the prescaler count never passes its limit
  a_r8_presc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    presc_cnt_q <= presc_val_q);
  // R9: a due refresh is kept until the sequencer takes it
  a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ref_ack) |=> pend_q);
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int BA_W  = 2,
  parameter int TRCD  = 2,
  parameter int TRP   = 3,
  parameter int TRFC  = 7,
  parameter int TMRD  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   op,
  input  logic [ROW_W+BA_W-1:0]        mode_data,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [COL_W+ROW_W+BA_W-1:0]  acc_addr,
  input  logic                         ref_pend,
  output logic                         ref_ack,
  output sd_cmd_e                      cmd,
  output logic [ROW_W-1:0]             sd_addr,
  output logic [BA_W-1:0]              sd_ba,
  output logic                         busy
);
  localparam int T1     = (TRP > TRCD) ? TRP : TRCD;
  localparam int T2     = (TRFC > TMRD) ? TRFC : TMRD;
  localparam int TMAX   = (T1 > T2) ? T1 : T2;
  localparam int WAIT_W = $clog2(TMAX + 1);
  localparam logic [ROW_W-1:0] A10_MASK = ROW_W'(1) << A10_BIT;

  seq_st_e              st_q, st_d;
  sd_cmd_e              cmd_q, cmd_d;
  logic [ROW_W-1:0]     addr_q, addr_d;
  logic [BA_W-1:0]      ba_q, ba_d, bank_q, bank_d;
  logic [COL_W-1:0]     col_q, col_d;
  logic                 rw_q, rw_d, busy_q, busy_d;
  logic [WAIT_W-1:0]    wait_q, wait_d;
  logic [COL_W-1:0]     acc_col;
  logic [ROW_W-1:0]     acc_row;
  logic [BA_W-1:0]      acc_bank;

  assign acc_col  = acc_addr[COL_W-1:0];
  assign acc_row  = acc_addr[COL_W +: ROW_W];
  assign acc_bank = acc_addr[COL_W+ROW_W +: BA_W];
  assign ref_ack  = (st_q == ST_IDLE) && ref_pend && (op == OP_NORMAL);

  always_comb begin
    st_d   = st_q;
    cmd_d  = CMD_DESEL;
    addr_d = '0;
    ba_d   = '0;
    bank_d = bank_q;
    col_d  = col_q;
    rw_d   = rw_q;
    wait_d = wait_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_ack) begin
          cmd_d  = CMD_REF;
          wait_d = WAIT_W'(TRFC - 1);
          st_d   = ST_RECOVER;
        end else if (acc_valid) begin
          if (op == OP_NORMAL) begin
            cmd_d  = CMD_ACT;
            addr_d = acc_row;
            ba_d   = acc_bank;
            bank_d = acc_bank;
            col_d  = acc_col;
            rw_d   = acc_write;
            wait_d = WAIT_W'(TRCD - 1);
            st_d   = ST_ACT_WAIT;
          end else if (acc_write && (op == OP_PREALL)) begin
            cmd_d  = CMD_PRE;
            addr_d = A10_MASK;
            wait_d = WAIT_W'(TRP - 1);
            st_d   = ST_RECOVER;
          end else if (acc_write && (op == OP_REFRESH)) begin
            cmd_d  = CMD_REF;
            wait_d = WAIT_W'(TRFC - 1);
            st_d   = ST_RECOVER;
          end else if (acc_write && (op == OP_MODESET)) begin
            cmd_d  = CMD_MRS;
            addr_d = mode_data[ROW_W-1:0];
            ba_d   = mode_data[ROW_W +: BA_W];
            wait_d = WAIT_W'(TMRD - 1);
            st_d   = ST_RECOVER;
          end
        end
      end
      ST_ACT_WAIT: begin
        if (wait_q == '0) begin
          cmd_d  = rw_q ? CMD_WR : CMD_RD;
          addr_d = ROW_W'(col_q) | A10_MASK;
          ba_d   = bank_q;
          wait_d = WAIT_W'(TRP - 1);
          st_d   = ST_RECOVER;
        end else begin
          wait_d = wait_q - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (wait_q == '0) st_d = ST_IDLE;
        else              wait_d = wait_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    busy_d = (st_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_DESEL;
      addr_q <= '0;
      ba_q   <= '0;
      bank_q <= '0;
      col_q  <= '0;
      rw_q   <= 1'b0;
      wait_q <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
      bank_q <= bank_d;
      col_q  <= col_d;
      rw_q   <= rw_d;
      wait_q <= wait_d;
      busy_q <= busy_d;
    end
  end

  assign cmd     = cmd_q;
  assign sd_addr = addr_q;
  assign sd_ba   = ba_q;
  assign busy    = busy_q;

  // R3: each busy window opens with a real command on the pins
  a_r3_cmd_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cmd_q != CMD_DESEL));
  // R3: during recovery past the first cycle only deselect is driven
  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RECOVER) && ($past(st_q) == ST_RECOVER)) |-> (cmd_q == CMD_DESEL));
  // R6: column commands only follow the activate wait
  a_r6_rw_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) |-> ($past(st_q) == ST_ACT_WAIT));
  // R9: a refresh on the pins needs normal or refresh operation selected
  a_r9_ref_op_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (($past(op) == OP_NORMAL) || ($past(op) == OP_REFRESH)));
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int BA_W     = 2,
  parameter int PRESC_W  = 8,
  parameter int PERIOD_W = 8,
  parameter int TRCD     = 2,
  parameter int TRP      = 3,
  parameter int TRFC     = 7,
  parameter int TMRD     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_we,
  input  logic [31:0]                 mode_wdata,
  input  logic                        presc_we,
  input  logic [PRESC_W-1:0]          presc_wdata,
  input  logic                        period_we,
  input  logic [PERIOD_W-1:0]         period_wdata,
  input  logic                        acc_valid,
  input  logic                        acc_write,
  input  logic [COL_W+ROW_W+BA_W-1:0] acc_addr,
  output logic                        sd_cs_n,
  output logic                        sd_ras_n,
  output logic                        sd_cas_n,
  output logic                        sd_we_n,
  output logic [ROW_W-1:0]            sd_addr,
  output logic [BA_W-1:0]             sd_ba,
  output logic                        busy
);
  localparam int MD_W = ROW_W + BA_W;

  logic [31:0] mode_q, mode_d;
  logic        ref_pend, ref_ack;
  sd_cmd_e     cmd;

  always_comb mode_d = mode_we ? mode_wdata : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  sdram_refresh_timer #(
    .PRESC_W (PRESC_W),
    .PERIOD_W(PERIOD_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .presc_we    (presc_we),
    .presc_wdata (presc_wdata),
    .period_we   (period_we),
    .period_wdata(period_wdata),
    .ref_ack     (ref_ack),
    .ref_pend    (ref_pend)
  );

  sdram_cmd_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W),
    .TRCD(TRCD), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (mode_q[OP_LSB +: 3]),
    .mode_data(mode_q[MD_W-1:0]),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .ref_pend (ref_pend),
    .ref_ack  (ref_ack),
    .cmd      (cmd),
    .sd_addr  (sd_addr),
    .sd_ba    (sd_ba),
    .busy     (busy)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // R7: an access seen while busy leaves the window open without a new command
  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid && (cmd == CMD_DESEL) && $past(busy)) |=>
      (!busy || (cmd != CMD_PRE && cmd != CMD_MRS && cmd != CMD_ACT)));
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int TRCD = 2, TRP = 3, TRFC = 7, TMRD = 2;
  localparam logic [3:0] C_DES = 4'b1111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0, presc_we = 1'b0, period_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic [7:0] presc_wdata = '0, period_wdata = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, busy;
  logic [12:0] sd_addr;
  logic [1:0] sd_ba;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] cur_mode = '0;

  always #4 clk = ~clk;

  sdram_cmd_seq i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .presc_we(presc_we), .presc_wdata(presc_wdata), .period_we(period_we),
    .period_wdata(period_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .busy(busy));

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input logic [2:0] op, input logic w);
    case (op)
      3'b000:  return C_ACT;
      3'b101:  return w ? C_PRE : C_DES;
      3'b001:  return w ? C_REF : C_DES;
      3'b011:  return w ? C_MRS : C_DES;
      default: return C_DES;
    endcase
  endfunction

  function automatic int exp_blen(input logic [2:0] op, input logic w);
    case (exp_cmd(op, w))
      C_ACT: return TRCD + TRP;
      C_PRE: return TRP;
      C_REF: return TRFC;
      C_MRS: return TMRD;
      default: return 0;
    endcase
  endfunction

  function automatic logic [14:0] exp_ab(input logic [3:0] c, input logic [23:0] a,
                                         input logic [31:0] m);
    case (c)
      C_ACT: return {a[23:22], a[21:9]};
      C_PRE: return 15'h0400;
      C_MRS: return m[14:0];
      default: return 15'h0000;
    endcase
  endfunction

  task automatic set_mode(input logic [31:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0; cyc++;
    cur_mode = v;
  endtask

  task automatic set_timer(input logic [7:0] p, input logic [7:0] t);
    @(negedge clk); presc_we = 1'b1; period_we = 1'b1;
    presc_wdata = p; period_wdata = t;
    @(negedge clk); presc_we = 1'b0; period_we = 1'b0; cyc++;
  endtask

  // performs one access and checks every pin and busy cycle it causes
  task automatic run_access(input logic w, input logic [23:0] a, input string tag);
    logic [2:0] op;
    logic [3:0] ec, c0;
    logic [14:0] ab0;
    int blen, eb;
    bit extra;
    bit rw_ok;
    op = cur_mode[29:27];
    ec = exp_cmd(op, w);
    eb = exp_blen(op, w);
    @(negedge clk); acc_valid = 1'b1; acc_write = w; acc_addr = a;
    @(negedge clk); acc_valid = 1'b0; cyc++;
    c0 = pins(); ab0 = {sd_ba, sd_addr};
    chk(c0 == ec, {tag, " R2 R3 command"}, 32'(c0), 32'(ec));
    chk(ab0 == exp_ab(ec, a, cur_mode), {tag, " R4 R5 R6 addr/bank"},
        32'(ab0), 32'(exp_ab(ec, a, cur_mode)));
    blen = 0; extra = 1'b0; rw_ok = (ec != C_ACT);
    while (busy && blen < 60) begin
      if (ec == C_ACT && blen == TRCD) begin
        rw_ok = (pins() == (w ? C_WR : C_RD)) &&
                ({sd_ba, sd_addr} == {a[23:22], 4'b0010, a[8:0]});
        if (!rw_ok) $display("FAIL %s R6 column cmd actual=%0h/%0h expected=%0h/%0h",
                             tag, pins(), {sd_ba, sd_addr}, (w ? C_WR : C_RD),
                             {a[23:22], 4'b0010, a[8:0]});
      end else if (blen > 0 && pins() != C_DES) extra = 1'b1;
      blen++;
      @(negedge clk); cyc++;
    end
    checks++;
    if (!rw_ok) failures++;
    chk(blen == eb, {tag, " R7 busy length"}, 32'(blen), 32'(eb));
    chk(!extra, {tag, " R3 single command"}, 32'(extra), 32'd0);
  endtask

  // waits up to lim cycles for a refresh on the pins; returns cycles waited or -1
  task automatic wait_ref(input int lim, output int waited);
    waited = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); cyc++;
      if (pins() == C_REF) begin waited = i; break; end
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0, w1, t0;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pins() == C_DES, "R1 pins after reset", 32'(pins()), 32'(C_DES));
    chk({sd_ba, sd_addr} == 15'h0 && !busy, "R1 addr/busy after reset",
        32'({busy, sd_ba, sd_addr}), 32'd0);

    // bring-up order: R4 R3 R5 R10
    set_mode(32'h6863_6733);
    run_access(1'b1, 24'h12_3456, "prechg R4");
    run_access(1'b0, 24'h12_3456, "prechg read ignored R2");
    set_mode(32'h4863_6733);
    for (int k = 0; k < 8; k++) run_access(1'b1, 24'(k * 4099), "refresh R3");
    set_mode(32'h5863_6733);
    run_access(1'b1, 24'h00_0000, "modeset R5 R10");
    set_mode(32'h4063_6733);
    run_access(1'b1, 24'hC0_03FF, "normal write R6");
    run_access(1'b0, 24'h7F_FE01, "normal read R6");
    // undefined operation codes ignored (R2)
    set_mode(32'h5063_6733);
    run_access(1'b1, 24'h00_1111, "op010 R2");
    set_mode(32'h7863_6733);
    run_access(1'b1, 24'h00_2222, "op111 R2");

    // access while busy is ignored (R7)
    set_mode(32'h4863_6733);
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b1;
    @(negedge clk); acc_valid = 1'b0; cyc++;
    @(negedge clk); acc_valid = 1'b1;
    @(negedge clk); acc_valid = 1'b0;
    t0 = 2;
    begin
      int nref;
      nref = 0;
      while (busy && t0 < 40) begin
        if (pins() == C_REF) nref++;
        t0++; @(negedge clk); cyc++;
      end
      chk(nref == 0, "R7 no command from access while busy", 32'(nref), 32'd0);
      chk(t0 == TRFC, "R7 busy window unchanged", 32'(t0), 32'(TRFC));
    end

    // refresh timer (R8)
    set_mode(32'h4063_6733);
    set_timer(8'd3, 8'd4);
    wait_ref(60, w0);
    chk(w0 >= 0, "R8 first auto refresh", 32'(w0), 32'd0);
    wait_ref(60, w1);
    chk(w1 + 1 == 20, "R8 refresh spacing", 32'(w1 + 1), 32'd20);
    // hold off while not normal (R9)
    set_mode(32'h6863_6733);
    wait_ref(60, w1);
    chk(w1 < 0, "R9 no refresh while special op", 32'(w1), 32'hFFFF_FFFF);
    set_mode(32'h4063_6733);
    @(negedge clk); cyc++;
    chk(pins() == C_REF, "R9 held refresh issued on return", 32'(pins()), 32'(C_REF));
    wait_ref(60, w1);
    set_timer(8'd3, 8'd0);
    wait_ref(60, w1);
    chk(w1 < 0, "R8 period zero stops refresh", 32'(w1), 32'hFFFF_FFFF);

    // random phase: R2 R3 R4 R5 R6 R7 R10
    for (int n = 0; n < 60; n++) begin
      logic [2:0] ops [6];
      logic [2:0] op;
      logic [31:0] m;
      ops = '{3'b000, 3'b101, 3'b001, 3'b011, 3'b010, 3'b110};
      op = ops[$urandom % 6];
      m = {2'b01, op, 27'($urandom)};
      if ((n % 3) == 0) set_mode(m);
      else set_mode({cur_mode[31:30], op, cur_mode[26:0]});
      run_access(1'($urandom), 24'($urandom), "random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule